// File: doc/BRIEF.md
# Two-Level Interrupt Priority Resolver

The resolver looks at eight interrupt request lines, each tagged with a one-bit priority level, and decides which source the processor should service next. Any eligible high-level request beats every low-level request. Among requests of the same level, a fixed polling order decides. Source 0 (external 0) is polled first, then timer 0, external 1, timer 1, serial port and timer 2. The two extra external sources, external 2 and external 3, come last. The winner is presented as a source index together with its fixed vector address. The address is 03H plus eight times the index, so it runs 03H, 0BH, 13H, ... 3BH.

The resolver also keeps the nesting state of the handlers. A low-level handler in service can be interrupted only by a high-level request. A high-level handler in service blocks every request until a return pulse arrives. A global enable gates every grant.

The grant leaves on a valid/ready pair. `grant_valid` is computed each cycle from the current requests and the nesting state. It may fall without a handshake if the request that caused it is withdrawn or the enable drops. The handshake completes in a cycle where `grant_valid` and `grant_ready` are both high. That cycle is the single grant pulse, and the nesting state takes the winner's level at the same clock edge. While `grant_ready` is low, the nesting state holds. The offer stays unchanged as long as the inputs do.

Top module: `irq_prio_resolver`

## Requirements
- R1: After reset both in-service flags (`svc_hi`, `svc_lo`) are 0. With no requests, `grant_valid` is 0.
- R2: When any eligible request has its level bit set (1 = high level), the granted source is a high-level one.
- R3: Among eligible requests of the winning level, the source with the lowest index wins (index 0 = external 0 ... 6 = external 2, 7 = external 3).
- R4: `grant_vec` equals 3 + 8 × `grant_idx` (03H for index 0, 3BH for index 7).
- R5: While `glb_en` is 0, `grant_valid` is 0.
- R6: A handshake with a high-level winner sets `svc_hi` at that clock edge. A handshake with a low-level winner sets `svc_lo`. The other flag is unchanged.
- R7: While `svc_hi` is 1, `grant_valid` is 0.
- R8: While `svc_lo` is 1 and `svc_hi` is 0, only high-level requests are eligible.
- R9: A `reti_pulse` clears `svc_hi` if it is set, and otherwise clears `svc_lo`. A pulse with neither flag set changes nothing.
- R10: In a cycle where `reti_pulse` is 1, `grant_valid` is 0 and no handshake occurs.
- R11: While `grant_ready` is 0, the in-service flags do not change except through `reti_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | 8 | Request lines, bit i = source i |
| irq_hi | input | 8 | Level bit per source, 1 = high |
| glb_en | input | 1 | Global acceptance enable |
| reti_pulse | input | 1 | Return-from-handler pulse |
| grant_ready | input | 1 | Processor accepts the offered grant |
| grant_valid | output | 1 | A grant is offered |
| grant_idx | output | 3 | Winning source index |
| grant_vec | output | 8 | Vector address of the winner |
| svc_hi | output | 1 | A high-level handler is in service |
| svc_lo | output | 1 | A low-level handler is in service |

## Verification
The bench places a low-index low-level request next to a high-index high-level one. A resolver that polled across both levels would hand index 0 the grant. It builds a nest of a low-level handler pre-empted by a high-level one and unwinds it with two return pulses. A tracker that cleared the wrong flag, or cleared both, shows up in the in-service outputs. It holds `grant_ready` low over a pending request to catch state that moves without a handshake, and raises a return pulse together with a pending request to catch a grant leaking through that cycle. Random mixes of requests, levels, enable and ready, checked against a bench model, cover the vector arithmetic and the same-level order.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;
  typedef struct packed {
    logic hi;
    logic lo;
  } svc_state_t;
endpackage

// File: rtl/irq_lvl_pick.sv
module irq_lvl_pick #(
  parameter int N_SRC = 8,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] mask,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (mask[i]) idx = IDX_W'(i);
    end
  end
  assign any = |mask;
endmodule

// File: rtl/irq_vec_enc.sv
module irq_vec_enc #(
  parameter int N_SRC      = 8,
  parameter int VEC_W      = 8,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic [IDX_W-1:0] idx,
  output logic [VEC_W-1:0] vec
);
  always_comb vec = VEC_W'(VEC_BASE + VEC_STRIDE * int'(idx));
endmodule

// File: rtl/irq_nest_state.sv
module irq_nest_state
  import irq_res_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  logic       take_hi,
  input  logic       reti,
  output svc_state_t st
);
  svc_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (reti) begin
      if (st_q.hi) st_d.hi = 1'b0;
      else         st_d.lo = 1'b0;
    end else if (take) begin
      if (take_hi) st_d.hi = 1'b1;
      else         st_d.lo = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign st = st_q;

  // R9
  reti_pop_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reti && st_q.hi |=> !st_q.hi && (st_q.lo == $past(st_q.lo)));
  // R9
  reti_pop_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reti && !st_q.hi |=> !st_q.lo && !st_q.hi);
  // R6
  take_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && take_hi && !reti |=> st_q.hi && (st_q.lo == $past(st_q.lo)));
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
  import irq_res_pkg::*;
#(
  parameter int N_SRC      = 8,
  parameter int VEC_W      = 8,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_req,
  input  logic [N_SRC-1:0] irq_hi,
  input  logic             glb_en,
  input  logic             reti_pulse,
  input  logic             grant_ready,
  output logic             grant_valid,
  output logic [IDX_W-1:0] grant_idx,
  output logic [VEC_W-1:0] grant_vec,
  output logic             svc_hi,
  output logic             svc_lo
);
  svc_state_t st;
  logic [N_SRC-1:0] elig;
  logic [N_SRC-1:0] lvl_mask [2];
  logic [1:0]       lvl_any;
  logic [IDX_W-1:0] lvl_idx  [2];
  logic             take;

  // Eligibility: enable, no return this cycle, nesting filter.
  always_comb begin
    if (!glb_en || reti_pulse || st.hi) elig = '0;
    else if (st.lo)                     elig = irq_req & irq_hi;
    else                                elig = irq_req;
  end

  assign lvl_mask[0] = elig & irq_hi;
  assign lvl_mask[1] = elig & ~irq_hi;

  for (genvar g = 0; g < 2; g++) begin : g_lvl
    irq_lvl_pick #(.N_SRC(N_SRC)) pick_i (
      .mask (lvl_mask[g]),
      .any  (lvl_any[g]),
      .idx  (lvl_idx[g])
    );
  end

  assign grant_valid = |lvl_any;
  assign grant_idx   = lvl_any[0] ? lvl_idx[0] : lvl_idx[1];
  assign take        = grant_valid && grant_ready;

  irq_vec_enc #(
    .N_SRC(N_SRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
  ) enc_i (
    .idx (grant_idx),
    .vec (grant_vec)
  );

  irq_nest_state nest_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .take_hi (lvl_any[0]),
    .reti    (reti_pulse),
    .st      (st)
  );

  assign svc_hi = st.hi;
  assign svc_lo = st.lo;

  // R5
  en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |-> !grant_valid);
  // R7
  hi_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_hi |-> !grant_valid);
  // R8
  lo_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_lo && grant_valid |-> irq_hi[grant_idx]);
  // R2
  hi_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid && !irq_hi[grant_idx] |-> (irq_req & irq_hi) == '0);
  // R10
  reti_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reti_pulse |-> !grant_valid);
  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_ready && !reti_pulse |=> $stable(svc_hi) && $stable(svc_lo));
  // R1
  req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> irq_req[grant_idx]);
endmodule

// File: tb/irq_prio_resolver_tb.sv
module irq_prio_resolver_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_req = '0, irq_hi = '0;
  logic       glb_en = 1'b0, reti_pulse = 1'b0, grant_ready = 1'b0;
  logic       grant_valid, svc_hi, svc_lo;
  logic [2:0] grant_idx;
  logic [7:0] grant_vec;

  int n_chk = 0, n_bad = 0;
  bit m_hi = 0, m_lo = 0;

  always #2 clk = ~clk;

  irq_prio_resolver dut_i (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_hi(irq_hi),
    .glb_en(glb_en), .reti_pulse(reti_pulse), .grant_ready(grant_ready),
    .grant_valid(grant_valid), .grant_idx(grant_idx), .grant_vec(grant_vec),
    .svc_hi(svc_hi), .svc_lo(svc_lo)
  );

  function automatic int low_bit(input logic [7:0] m);
    for (int i = 7; i >= 0; i--) if (m[i]) low_bit = i;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] rq, input logic [7:0] hl,
                      input bit en, input bit rdy, input bit rt);
    logic [7:0] el, hm, pk;
    bit ev;
    int ei;
    string vt;
    @(negedge clk);
    irq_req = rq; irq_hi = hl; glb_en = en; grant_ready = rdy; reti_pulse = rt;
    #1;
    if (!en || rt || m_hi) el = '0;
    else if (m_lo)         el = rq & hl;
    else                   el = rq;
    hm = el & hl;
    pk = (hm != 0) ? hm : el;
    ev = (pk != 0);
    ei = ev ? low_bit(pk) : 0;
    if (!en)       vt = "R5";
    else if (rt)   vt = "R10";
    else if (m_hi) vt = "R7";
    else if (m_lo) vt = "R8";
    else           vt = "R6";
    chk(grant_valid == ev, vt, grant_valid, ev);
    if (ev && grant_valid) begin
      chk(int'(grant_idx) == ei, (hm != 0) ? "R2" : "R3", grant_idx, ei);
      chk(int'(grant_vec) == 3 + 8 * ei, "R4", grant_vec, 3 + 8 * ei);
    end
    chk(svc_hi == m_hi, rt ? "R9" : (!rdy ? "R11" : "R6"), svc_hi, m_hi);
    chk(svc_lo == m_lo, rt ? "R9" : (!rdy ? "R11" : "R6"), svc_lo, m_lo);
    if (rt) begin
      if (m_hi) m_hi = 0;
      else      m_lo = 0;
    end else if (ev && rdy) begin
      if (hl[ei]) m_hi = 1;
      else        m_lo = 1;
    end
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    #1;
    // R1: reset state
    chk(svc_hi == 0 && svc_lo == 0, "R1", {svc_hi, svc_lo}, 0);
    #10 rst_n = 1'b1;
    step(8'h00, 8'h00, 1, 1, 0);
    // R5: enable low masks everything
    step(8'hFF, 8'hFF, 0, 1, 0);
    // R2: index 7 high beats index 0 low; ready low first (R11)
    step(8'h81, 8'h80, 1, 0, 0);
    step(8'h81, 8'h80, 1, 0, 0);
    // R3: same-level order, take low index 2 over 5
    step(8'h24, 8'h00, 1, 1, 0);
    // R8: low in service, only high index 6 accepted, low 0 ignored
    step(8'h41, 8'h40, 1, 0, 0);
    step(8'h41, 8'h40, 1, 1, 0);
    // R7: high in service blocks all
    step(8'hFF, 8'hFF, 1, 1, 0);
    // R10 and R9: return pops high, grant blocked
    step(8'hFF, 8'hFF, 1, 1, 1);
    // R9: return pops low
    step(8'h00, 8'h00, 1, 1, 1);
    // R9: return with nothing in service
    step(8'h00, 8'h00, 1, 1, 1);
    // R4: vector for index 7 (3BH)
    step(8'h80, 8'h00, 1, 0, 0);
    // random mix
    for (int k = 0; k < 3000; k++) begin
      step(8'($urandom), 8'($urandom), ($urandom % 8) != 0,
           ($urandom % 3) != 0, ($urandom % 4) == 0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule